// File: doc/BRIEF.md
# Prioritized Daisy-Chain Interrupter

This block lets a module raise an interrupt on one of seven prioritized request lines of a shared backplane bus. It then takes part in the acknowledge daisy chain that follows. A local event latches a pending request. The request drives the one active-low request line selected by the configured level. Level code 0 disables the interrupter.

When the interrupt handler runs an acknowledge cycle, the block compares the level code on address lines 3..1 with its configured level. It claims the cycle only when the codes match and a request is pending. A claimed cycle returns an 8-bit configurable vector on the data lines under a four-edge data-strobe/acknowledge handshake. In every other case the block forwards the incoming acknowledge to its outgoing acknowledge pin, so modules further down the chain still see it.

The pending request is released in one of two ways, chosen by a mode input:
- In clear-on-acknowledge mode, the request drops as soon as the vector is delivered.
- In clear-on-access mode, the request survives the acknowledge cycle. It drops only when the local register decoder reports an access to the clear register.

All bus inputs are assumed to be synchronized to `clk` before they reach the block.

Top module: `daisy_irq_node`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, all request lines are high, the outgoing acknowledge is high, the acknowledge strobe is high, the data enable is low and the data lines read 0.
- R2: An event with level code k (1 to 7) pulls request line index k-1 low after the next clock edge, and no other line. With level code 0 no line goes low. At most one line is ever low.
- R3: An acknowledge cycle whose address level code equals the configured level, while a request is pending, is claimed. The outgoing acknowledge stays high for the whole cycle.
- R4: An acknowledge cycle that is not claimed (level code mismatch, or nothing pending) drives the outgoing acknowledge low one cycle after the incoming acknowledge goes low. The outgoing acknowledge goes high one cycle after the incoming acknowledge returns high. A passed cycle leaves the pending request untouched.
- R5: In a claimed cycle, one cycle after data strobe goes low, the acknowledge strobe goes low, the data enable goes high and the data lines carry the configured vector. One cycle after data strobe returns high, the acknowledge strobe returns high and the data lines return to 0 with the enable low. A passed cycle never drives the acknowledge strobe.
- R6: With mode input 0 (clear-on-acknowledge), the request line goes high in the same cycle that the acknowledge strobe goes low.
- R7: With mode input 1 (clear-on-access), the request line stays low through and after the acknowledge cycle. It goes high one cycle after a clear-register strobe.
- R8: With mode input 0, a clear-register strobe has no effect on a pending request.
- R9: An event and a clear-register strobe in the same cycle leave the request pending: the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_i | input | 1 | Local interrupt event, one-cycle pulse |
| cfg_level_i | input | 3 | Request level, 1 to 7; 0 disables |
| cfg_vector_i | input | 8 | Vector returned in a claimed cycle |
| cfg_release_on_access_i | input | 1 | 0: clear on acknowledge, 1: clear on register access |
| clr_hit_i | input | 1 | Strobe from the local decoder: clear register accessed |
| bus_lvl_i | input | 3 | Address lines 3..1, acknowledged level code |
| bus_as_n_i | input | 1 | Address strobe, active low |
| bus_ds_n_i | input | 1 | Data strobe, active low |
| iack_in_n_i | input | 1 | Incoming daisy-chain acknowledge, active low |
| iack_out_n_o | output | 1 | Outgoing daisy-chain acknowledge, active low |
| irq_n_o | output | 7 | Request lines, index k-1 for level k, active low |
| data_o | output | 8 | Vector data, valid while data_oe_o is high |
| data_oe_o | output | 1 | Enable for the data line drivers |
| dtack_n_o | output | 1 | Data acknowledge strobe, active low |

## Verification
A wrong pending flag shows up on the request lines one cycle after the event or clear that caused it. It shows up again in the claim-or-pass decision, one cycle after the incoming acknowledge falls: a stale flag either blocks the chain or answers a cycle the module does not own. A chain state that is stuck or wrong is visible as an outgoing acknowledge that does not track the incoming one within one cycle. A bad handshake state shows as an acknowledge strobe or data enable that misses the data strobe edge by more than one cycle. Each scenario checks both release modes against the request lines in the same cycle the acknowledge strobe falls.

// File: rtl/irq_pkg.sv
// Shared definitions for the daisy-chain interrupter.
// Assumes: nothing beyond the parameter values below.
package irq_pkg;
    localparam int unsigned IRQ_LEVELS = 7;
    localparam int unsigned IRQ_LW     = $clog2(IRQ_LEVELS + 1);
    localparam int unsigned IRQ_VW     = 8;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_PASS  = 2'd1,
        CH_CLAIM = 2'd2
    } chain_state_e;
endpackage

// File: rtl/irq_request.sv
// Pending-request latch and request-line decode.
// Holds one pending flag, set by a local event when a nonzero level is
// configured. The flag clears on acknowledge or on a clear strobe,
// depending on the mode input. An event dominates a clear in the same cycle.
// Assumes: inputs synchronous to clk.
module irq_request #(
    parameter int unsigned LEVELS = 7,
    parameter int unsigned LW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_i,
    input  logic [LW-1:0]     level_i,
    input  logic              release_on_access_i,
    input  logic              clr_hit_i,
    input  logic              ack_start_i,
    output logic              pending_o,
    output logic [LEVELS-1:0] irq_n_o
);
    logic pending_q;
    logic level_on;
    logic clear_now;

    assign level_on  = (level_i != '0);
    assign clear_now = release_on_access_i ? clr_hit_i : ack_start_i;

    // Pending flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (event_i && level_on)
            pending_q <= 1'b1;
        else if (clear_now)
            pending_q <= 1'b0;
    end

    assign pending_o = pending_q;

    // One request line per level; only the configured one may go low.
    for (genvar k = 0; k < LEVELS; k++) begin : g_line
        assign irq_n_o[k] = !(pending_q && (level_i == LW'(k + 1)));
    end
endmodule

// File: rtl/iack_chain.sv
// Acknowledge daisy-chain node.
// When the incoming acknowledge and address strobe are both low, it decides
// once between claiming the cycle (level code matches and a request is
// pending) and passing it on. It holds that decision until the incoming
// acknowledge is released. The outgoing acknowledge is a dedicated flop, so
// it cannot glitch low while the cycle is claimed.
// Assumes: inputs synchronous to clk.
module iack_chain #(
    parameter int unsigned LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_n_i,
    input  logic          iack_in_n_i,
    input  logic [LW-1:0] bus_lvl_i,
    input  logic [LW-1:0] level_i,
    input  logic          pending_i,
    output logic          iack_out_n_o,
    output logic          claim_o
);
    import irq_pkg::*;

    chain_state_e state_q, state_d;
    logic         out_n_q;

    // Next-state decision for the chain node.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (!iack_in_n_i && !as_n_i) begin
                    if (pending_i && (bus_lvl_i == level_i))
                        state_d = CH_CLAIM;
                    else
                        state_d = CH_PASS;
                end
            end
            CH_PASS, CH_CLAIM: begin
                if (iack_in_n_i)
                    state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // State and outgoing acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            out_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            out_n_q <= (state_d != CH_PASS);
        end
    end

    assign iack_out_n_o = out_n_q;
    assign claim_o      = (state_q == CH_CLAIM);
endmodule

// File: rtl/vector_driver.sv
// Vector return with a four-edge handshake.
// While the cycle is claimed, a low data strobe raises the acknowledge and
// drives the captured vector; a high data strobe drops both.
// Assumes: claim_i comes from a registered chain state.
module vector_driver #(
    parameter int unsigned VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_i,
    input  logic          ds_n_i,
    input  logic [VW-1:0] vector_i,
    output logic          ack_start_o,
    output logic          dtack_n_o,
    output logic [VW-1:0] data_o,
    output logic          data_oe_o
);
    logic          ack_q;
    logic [VW-1:0] vec_q;

    assign ack_start_o = claim_i && !ds_n_i && !ack_q;

    // Acknowledge flag and vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            vec_q <= '0;
        end else begin
            ack_q <= claim_i && !ds_n_i;
            if (ack_start_o)
                vec_q <= vector_i;
        end
    end

    assign dtack_n_o = !ack_q;
    assign data_oe_o = ack_q;
    assign data_o    = ack_q ? vec_q : '0;
endmodule

// File: rtl/daisy_irq_node.sv
// Top of the prioritized daisy-chain interrupter.
// Joins the request latch, the chain node and the vector driver.
// Assumes: all bus inputs are synchronized to clk before they arrive.
module daisy_irq_node #(
    parameter int unsigned LEVELS = irq_pkg::IRQ_LEVELS,
    parameter int unsigned LW     = irq_pkg::IRQ_LW,
    parameter int unsigned VW     = irq_pkg::IRQ_VW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_i,
    input  logic [LW-1:0]     cfg_level_i,
    input  logic [VW-1:0]     cfg_vector_i,
    input  logic              cfg_release_on_access_i,
    input  logic              clr_hit_i,
    input  logic [LW-1:0]     bus_lvl_i,
    input  logic              bus_as_n_i,
    input  logic              bus_ds_n_i,
    input  logic              iack_in_n_i,
    output logic              iack_out_n_o,
    output logic [LEVELS-1:0] irq_n_o,
    output logic [VW-1:0]     data_o,
    output logic              data_oe_o,
    output logic              dtack_n_o
);
    logic pending;
    logic claim;
    logic ack_start;

    irq_request #(.LEVELS(LEVELS), .LW(LW)) u_req (
        .clk                 (clk),
        .rst_n               (rst_n),
        .event_i             (event_i),
        .level_i             (cfg_level_i),
        .release_on_access_i (cfg_release_on_access_i),
        .clr_hit_i           (clr_hit_i),
        .ack_start_i         (ack_start),
        .pending_o           (pending),
        .irq_n_o             (irq_n_o)
    );

    iack_chain #(.LW(LW)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n_i       (bus_as_n_i),
        .iack_in_n_i  (iack_in_n_i),
        .bus_lvl_i    (bus_lvl_i),
        .level_i      (cfg_level_i),
        .pending_i    (pending),
        .iack_out_n_o (iack_out_n_o),
        .claim_o      (claim)
    );

    vector_driver #(.VW(VW)) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_i     (claim),
        .ds_n_i      (bus_ds_n_i),
        .vector_i    (cfg_vector_i),
        .ack_start_o (ack_start),
        .dtack_n_o   (dtack_n_o),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o)
    );
endmodule

// File: rtl/daisy_irq_node_chk.sv
// Port-level protocol checker for daisy_irq_node, attached by bind.
module daisy_irq_node_chk #(
    parameter int unsigned LEVELS = 7,
    parameter int unsigned LW     = 3,
    parameter int unsigned VW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              event_i,
    input logic [LW-1:0]     cfg_level_i,
    input logic [VW-1:0]     cfg_vector_i,
    input logic              cfg_release_on_access_i,
    input logic              clr_hit_i,
    input logic [LW-1:0]     bus_lvl_i,
    input logic              bus_as_n_i,
    input logic              bus_ds_n_i,
    input logic              iack_in_n_i,
    input logic              iack_out_n_o,
    input logic [LEVELS-1:0] irq_n_o,
    input logic [VW-1:0]     data_o,
    input logic              data_oe_o,
    input logic              dtack_n_o
);
    AST_ONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n_o)); // R2

    AST_CLAIM_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n_o |-> iack_out_n_o); // R3

    AST_PASS_NEEDS_IACKIN: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_out_n_o |-> !$past(iack_in_n_i)); // R4

    AST_CHAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_in_n_i) |=> iack_out_n_o); // R4

    AST_DTACK_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> !$past(bus_ds_n_i)); // R5

    AST_DATA_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0)); // R5

    AST_ACK_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_release_on_access_i && $stable(cfg_release_on_access_i)
         && $fell(dtack_n_o) && !$past(event_i)) |-> (&irq_n_o)); // R6

    AST_ACCESS_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_release_on_access_i && $stable(cfg_release_on_access_i)
         && $stable(cfg_level_i) && $fell(dtack_n_o) && !$past(clr_hit_i))
        |-> !(&irq_n_o)); // R7
endmodule

bind daisy_irq_node daisy_irq_node_chk #(.LEVELS(LEVELS), .LW(LW), .VW(VW)) u_chk (.*);

// File: tb/test_daisy_irq_node.sv
`timescale 1ns/1ps
module test_daisy_irq_node;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       event_i;
    logic [2:0] cfg_level_i;
    logic [7:0] cfg_vector_i;
    logic       cfg_release_on_access_i;
    logic       clr_hit_i;
    logic [2:0] bus_lvl_i;
    logic       bus_as_n_i;
    logic       bus_ds_n_i;
    logic       iack_in_n_i;
    logic       iack_out_n_o;
    logic [6:0] irq_n_o;
    logic [7:0] data_o;
    logic       data_oe_o;
    logic       dtack_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    daisy_irq_node i_daisy_irq_node (.*);

    // Scenario fields: {mode, level, vector, bus level, fire event}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd3, 8'hA5, 3'd3, 1'b1},
        {1'b1, 3'd5, 8'h3C, 3'd5, 1'b1},
        {1'b0, 3'd2, 8'h11, 3'd4, 1'b1},
        {1'b1, 3'd7, 8'hFF, 3'd7, 1'b0},
        {1'b0, 3'd1, 8'h80, 3'd1, 1'b1},
        {1'b1, 3'd0, 8'h55, 3'd0, 1'b1},
        {1'b0, 3'd7, 8'h01, 3'd7, 1'b1},
        {1'b1, 3'd4, 8'h9A, 3'd6, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        event_i = 1'b0; clr_hit_i = 1'b0;
        bus_as_n_i = 1'b1; bus_ds_n_i = 1'b1; iack_in_n_i = 1'b1; bus_lvl_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_event();
        event_i = 1'b1;
        @(negedge clk);
        event_i = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_hit_i = 1'b1;
        @(negedge clk);
        clr_hit_i = 1'b0;
    endtask

    function automatic logic [6:0] line_pat(input logic [2:0] lvl, input bit on);
        logic [6:0] p = 7'h7F;
        if (on && lvl != 0) p[lvl-1] = 1'b0;
        return p;
    endfunction

    initial begin
        rst_n = 1'b0; event_i = 1'b0; clr_hit_i = 1'b0;
        cfg_level_i = '0; cfg_vector_i = '0; cfg_release_on_access_i = 1'b0;
        bus_lvl_i = '0; bus_as_n_i = 1'b1; bus_ds_n_i = 1'b1; iack_in_n_i = 1'b1;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1", "irq lines", irq_n_o, 7'h7F);
        chk("R1", "iack out", iack_out_n_o, 1'b1);
        chk("R1", "dtack", dtack_n_o, 1'b1);
        chk("R1", "data enable", data_oe_o, 1'b0);
        chk("R1", "data", data_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic       mode   = VEC[i][15];
            logic [2:0] lvl    = VEC[i][14:12];
            logic [7:0] vecv   = VEC[i][11:4];
            logic [2:0] alvl   = VEC[i][3:1];
            logic       fire   = VEC[i][0];
            bit         pend   = fire && (lvl != 0);
            bit         claim  = pend && (alvl == lvl);
            logic [6:0] pat    = line_pat(lvl, pend);

            cfg_release_on_access_i = mode;
            cfg_level_i = lvl;
            cfg_vector_i = vecv;
            do_reset();
            @(negedge clk);
            if (fire) pulse_event();
            chk("R2", "irq after event", irq_n_o, pat);

            // acknowledge cycle
            bus_lvl_i = alvl; bus_as_n_i = 1'b0; iack_in_n_i = 1'b0;
            @(negedge clk);
            chk(claim ? "R3" : "R4", "iack out after iack in", iack_out_n_o, claim ? 1'b1 : 1'b0);
            bus_ds_n_i = 1'b0;
            @(negedge clk);
            chk("R5", "dtack on ds", dtack_n_o, claim ? 1'b0 : 1'b1);
            chk("R5", "vector", data_o, claim ? vecv : 8'h00);
            chk("R5", "data enable", data_oe_o, claim ? 1'b1 : 1'b0);
            if (claim && !mode)
                chk("R6", "irq at dtack", irq_n_o, 7'h7F);
            else if (claim)
                chk("R7", "irq held at dtack", irq_n_o, pat);
            else
                chk("R4", "pass keeps request", irq_n_o, pat);
            chk(claim ? "R3" : "R4", "iack out mid cycle", iack_out_n_o, claim ? 1'b1 : 1'b0);
            bus_ds_n_i = 1'b1;
            @(negedge clk);
            chk("R5", "dtack release", dtack_n_o, 1'b1);
            chk("R5", "data enable release", data_oe_o, 1'b0);
            iack_in_n_i = 1'b1; bus_as_n_i = 1'b1;
            @(negedge clk);
            chk("R4", "iack out release", iack_out_n_o, 1'b1);
            if (claim && mode) begin
                chk("R7", "irq after cycle", irq_n_o, pat);
                pulse_clear();
                chk("R7", "irq after clear", irq_n_o, 7'h7F);
            end
        end

        // R8: clear strobe ignored in clear-on-acknowledge mode
        cfg_release_on_access_i = 1'b0; cfg_level_i = 3'd6;
        do_reset();
        @(negedge clk);
        pulse_event();
        pulse_clear();
        chk("R8", "irq after clear in ack mode", irq_n_o, 7'h5F);

        // R9: event and clear in the same cycle
        cfg_release_on_access_i = 1'b1; cfg_level_i = 3'd2;
        do_reset();
        @(negedge clk);
        pulse_event();
        event_i = 1'b1; clr_hit_i = 1'b1;
        @(negedge clk);
        event_i = 1'b0; clr_hit_i = 1'b0;
        chk("R9", "set wins over clear", irq_n_o, 7'h7D);
        pulse_clear();
        chk("R9", "clear alone", irq_n_o, 7'h7F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule